// File: doc/BRIEF.md
# Instruction Re-execution Result Checker

This block sits just before commit and independently recomputes every retiring instruction. The core hands it one instruction per cycle, in program order. Each instruction carries an opcode, the two register operands and immediate that the core used, the instruction's own address, the result the core produced and the next address the core followed. A two-stage pipeline recomputes the value in its first stage and compares it in its second. The commit controller then receives a pass flag, separate result and control-flow error flags, and the corrected result and next address, which it writes in place of the core's values when they disagree.

Every operand arrives already resolved by the core, so an instruction never waits on an older one. The block therefore has no bypass paths and no hazard detection. A result that depends on a slow instruction is accepted in the very next cycle. The instruction set is a small integer load/store set. Loads and stores reach this block only as their address-generation half (register plus constant); the memory access itself is checked elsewhere. Width, tag width, instruction size and an optional shifter are parameters.

Top module: `rexec_checker`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: An instruction accepted at a rising edge (in_valid and in_ready high) is presented on out_valid with its own out_tag after the next rising edge, i.e. two edges after it is first driven.
- R3: Opcode encoding and recomputed result: 0 a+b, 1 a-b, 2 a&b, 3 a|b, 4 a^b, 5 signed a<b giving 1 or 0, 6 a shifted left by the low log2(DATA_W) bits of b, 7 logical right shift by the same amount.
- R4: Opcode 8 is address generation: the recomputed result is a plus the immediate, modulo 2^DATA_W.
- R5: For an instruction whose result is compared, a difference between the core result and the recomputed value sets out_res_err, clears out_pass and drives the recomputed value on out_result; when they agree out_res_err is low and out_result equals the core result.
- R6: For opcodes that are not branches or jumps, the actual next address is pc + INSN_BYTES; a core next address that differs sets out_ctl_err and clears out_pass, and out_next_pc always carries the actual next address.
- R7: Conditional branches are opcode 9 (taken when a == b), 10 (taken when a != b) and 11 (taken when signed a < b); the actual next address is pc + imm when taken, otherwise pc + INSN_BYTES.
- R8: For conditional branches the core result is not compared: out_res_err stays low and out_result equals the core result whatever its value.
- R9: Opcode 12 is a jump: the actual next address is pc + imm and the recomputed result is the link value pc + INSN_BYTES, which is compared.
- R10: With out_ready held high, in_ready stays high and one instruction is accepted every cycle; results leave in the order of acceptance.
- R11: While out_valid is high and out_ready is low, all outputs hold their values; once both stages are full, in_ready is low and no instruction is accepted.
- R12: Opcodes 13 to 15 recompute a result of zero and the next address pc + INSN_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Retiring instruction present |
| in_ready | output | 1 | Checker can accept an instruction |
| in_tag | input | TAG_W | Instruction tag, passed through |
| in_op | input | 4 | Opcode |
| in_pc | input | DATA_W | Address of the instruction |
| in_opa | input | DATA_W | First operand as used by the core |
| in_opb | input | DATA_W | Second operand as used by the core |
| in_imm | input | DATA_W | Immediate / offset |
| in_core_res | input | DATA_W | Result produced by the core |
| in_core_npc | input | DATA_W | Next address followed by the core |
| out_valid | output | 1 | Check outcome present |
| out_ready | input | 1 | Commit controller takes the outcome |
| out_tag | output | TAG_W | Tag of the checked instruction |
| out_pass | output | 1 | Result and next address both correct |
| out_res_err | output | 1 | Result mismatch detected |
| out_ctl_err | output | 1 | Next-address mismatch detected |
| out_result | output | DATA_W | Corrected result |
| out_next_pc | output | DATA_W | Actual next address |

## Verification
The assertions assume the commit side obeys the handshake: an outcome stays offered until out_ready takes it. They also assume the core leaves in_valid and the instruction fields unchanged while in_ready is low. The bench changes inputs only at falling edges. Under backpressure it keeps the rejected instruction on the inputs until it is accepted, and it leaves out_ready high except in the scenario that tests stalling. Operand values are picked to reach signed and unsigned boundaries, wrap-around in address addition, and both outcomes of each branch condition.

// File: rtl/rexec_pkg.sv
package rexec_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_AND  = 4'd2,
      OP_OR   = 4'd3,
      OP_XOR  = 4'd4,
      OP_SLT  = 4'd5,
      OP_SLL  = 4'd6,
      OP_SRL  = 4'd7,
      OP_AGEN = 4'd8,
      OP_BEQ  = 4'd9,
      OP_BNE  = 4'd10,
      OP_BLT  = 4'd11,
      OP_JMP  = 4'd12
   } op_e;

   localparam int OP_W = 4;

   function automatic logic is_cond_branch(input logic [OP_W-1:0] op);
      return (op == OP_BEQ) || (op == OP_BNE) || (op == OP_BLT);
   endfunction

endpackage

// File: rtl/rexec_stage.sv
module rexec_stage #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         up_valid,
   output logic         up_ready,
   input  logic [W-1:0] up_data,
   output logic         dn_valid,
   input  logic         dn_ready,
   output logic [W-1:0] dn_data
);

   assign up_ready = !dn_valid || dn_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dn_valid <= 1'b0;
         dn_data  <= '0;
      end else if (up_ready) begin
         dn_valid <= up_valid;
         if (up_valid) dn_data <= up_data;
      end
   end

   AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && !dn_ready |=> dn_valid && $stable(dn_data)) // R11
      else $error("stage dropped or changed a stalled entry");

endmodule

// File: rtl/rexec_alu.sv
module rexec_alu
   import rexec_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int INSN_BYTES   = 4,
   parameter bit ENABLE_SHIFT = 1'b1
) (
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [DATA_W-1:0] imm,
   input  logic [DATA_W-1:0] pc,
   output logic [DATA_W-1:0] res
);

   localparam int SHW = $clog2(DATA_W);

   logic [DATA_W-1:0] shl_v;
   logic [DATA_W-1:0] shr_v;

   generate
      if (ENABLE_SHIFT) begin : g_shift
         logic [SHW-1:0] amt;
         assign amt   = b[SHW-1:0];
         assign shl_v = a << amt;
         assign shr_v = a >> amt;
      end else begin : g_noshift
         assign shl_v = '0;
         assign shr_v = '0;
      end
   endgenerate

   always_comb begin
      res = '0;
      case (op_e'(op))
         OP_ADD:  res = a + b;
         OP_SUB:  res = a - b;
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_SLT:  res = {{(DATA_W-1){1'b0}}, ($signed(a) < $signed(b))};
         OP_SLL:  res = shl_v;
         OP_SRL:  res = shr_v;
         OP_AGEN: res = a + imm;
         OP_JMP:  res = pc + DATA_W'(INSN_BYTES);
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/rexec_nextpc.sv
module rexec_nextpc
   import rexec_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int INSN_BYTES = 4
) (
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [DATA_W-1:0] imm,
   input  logic [DATA_W-1:0] pc,
   output logic [DATA_W-1:0] npc,
   output logic              res_checked
);

   logic [DATA_W-1:0] seq_pc;
   logic [DATA_W-1:0] tgt_pc;
   logic              taken;

   assign seq_pc = pc + DATA_W'(INSN_BYTES);
   assign tgt_pc = pc + imm;

   always_comb begin
      case (op_e'(op))
         OP_BEQ:  taken = (a == b);
         OP_BNE:  taken = (a != b);
         OP_BLT:  taken = ($signed(a) < $signed(b));
         OP_JMP:  taken = 1'b1;
         default: taken = 1'b0;
      endcase
   end

   assign npc         = taken ? tgt_pc : seq_pc;
   assign res_checked = !is_cond_branch(op);

endmodule

// File: rtl/rexec_checker.sv
module rexec_checker
   import rexec_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int TAG_W        = 4,
   parameter int INSN_BYTES   = 4,
   parameter bit ENABLE_SHIFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [TAG_W-1:0]  in_tag,
   input  logic [3:0]        in_op,
   input  logic [DATA_W-1:0] in_pc,
   input  logic [DATA_W-1:0] in_opa,
   input  logic [DATA_W-1:0] in_opb,
   input  logic [DATA_W-1:0] in_imm,
   input  logic [DATA_W-1:0] in_core_res,
   input  logic [DATA_W-1:0] in_core_npc,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [TAG_W-1:0]  out_tag,
   output logic              out_pass,
   output logic              out_res_err,
   output logic              out_ctl_err,
   output logic [DATA_W-1:0] out_result,
   output logic [DATA_W-1:0] out_next_pc
);

   initial begin
      assert (DATA_W >= 8) else $error("DATA_W must be at least 8");
      assert (TAG_W >= 1) else $error("TAG_W must be at least 1");
      assert (INSN_BYTES >= 1 && INSN_BYTES < (1 << 8))
         else $error("INSN_BYTES out of range");
      assert ((1 << $clog2(DATA_W)) == DATA_W) else $error("DATA_W must be a power of two");
   end

   typedef struct packed {
      logic [TAG_W-1:0]  tag;
      logic [OP_W-1:0]   op;
      logic [DATA_W-1:0] pc;
      logic [DATA_W-1:0] a;
      logic [DATA_W-1:0] b;
      logic [DATA_W-1:0] imm;
      logic [DATA_W-1:0] core_res;
      logic [DATA_W-1:0] core_npc;
   } ex_t;

   typedef struct packed {
      logic [TAG_W-1:0]  tag;
      logic [OP_W-1:0]   op;
      logic              res_checked;
      logic [DATA_W-1:0] re_res;
      logic [DATA_W-1:0] re_npc;
      logic [DATA_W-1:0] core_res;
      logic [DATA_W-1:0] core_npc;
   } cmp_t;

   localparam int EX_W  = $bits(ex_t);
   localparam int CMP_W = $bits(cmp_t);

   ex_t  ex_in, ex_q;
   cmp_t cmp_in, cmp_q;
   logic ex_valid, ex_ready;

   assign ex_in = '{tag: in_tag, op: in_op, pc: in_pc, a: in_opa, b: in_opb,
                    imm: in_imm, core_res: in_core_res, core_npc: in_core_npc};

   // Stage 1: capture the retiring instruction
   rexec_stage #(.W(EX_W)) u_ex_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_valid (in_valid),
      .up_ready (in_ready),
      .up_data  (ex_in),
      .dn_valid (ex_valid),
      .dn_ready (ex_ready),
      .dn_data  (ex_q)
   );

   // Recompute from the core-supplied operands
   logic [DATA_W-1:0] re_res;
   logic [DATA_W-1:0] re_npc;
   logic              res_checked;

   rexec_alu #(.DATA_W(DATA_W), .INSN_BYTES(INSN_BYTES), .ENABLE_SHIFT(ENABLE_SHIFT)) u_alu (
      .op  (ex_q.op),
      .a   (ex_q.a),
      .b   (ex_q.b),
      .imm (ex_q.imm),
      .pc  (ex_q.pc),
      .res (re_res)
   );

   rexec_nextpc #(.DATA_W(DATA_W), .INSN_BYTES(INSN_BYTES)) u_npc (
      .op          (ex_q.op),
      .a           (ex_q.a),
      .b           (ex_q.b),
      .imm         (ex_q.imm),
      .pc          (ex_q.pc),
      .npc         (re_npc),
      .res_checked (res_checked)
   );

   assign cmp_in = '{tag: ex_q.tag, op: ex_q.op, res_checked: res_checked,
                     re_res: re_res, re_npc: re_npc,
                     core_res: ex_q.core_res, core_npc: ex_q.core_npc};

   // Stage 2: hold recomputed and core values for comparison
   rexec_stage #(.W(CMP_W)) u_cmp_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_valid (ex_valid),
      .up_ready (ex_ready),
      .up_data  (cmp_in),
      .dn_valid (out_valid),
      .dn_ready (out_ready),
      .dn_data  (cmp_q)
   );

   logic res_diff;
   logic npc_diff;

   assign res_diff    = cmp_q.re_res != cmp_q.core_res;
   assign npc_diff    = cmp_q.re_npc != cmp_q.core_npc;
   assign out_tag     = cmp_q.tag;
   assign out_res_err = cmp_q.res_checked && res_diff;
   assign out_ctl_err = npc_diff;
   assign out_pass    = !(out_res_err || out_ctl_err);
   assign out_result  = cmp_q.res_checked ? cmp_q.re_res : cmp_q.core_res;
   assign out_next_pc = cmp_q.re_npc;

   // Occupancy tracking for ordering checks
   logic [1:0] occ;
   logic       acc_in, acc_out;

   assign acc_in  = in_valid && in_ready;
   assign acc_out = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) occ <= '0;
      else        occ <= occ + 2'(acc_in) - 2'(acc_out);
   end

   AST_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      out_ready |-> in_ready) // R10
      else $error("input stalled with output free");

   AST_OCC_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= 2'd2 && (out_valid -> occ != 2'd0)) // R10
      else $error("occupancy out of range");

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_tag) && $stable(out_result)
         && $stable(out_next_pc) && $stable(out_pass)) // R11
      else $error("output changed under backpressure");

   AST_CLEAN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_res_err |-> out_result == cmp_q.core_res) // R5
      else $error("result replaced without an error");

   AST_BRANCH_NO_RES: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && is_cond_branch(cmp_q.op) |-> !out_res_err) // R8
      else $error("branch flagged a result error");

endmodule

// File: tb/tb_rexec_checker.sv
module tb_rexec_checker;

   localparam int DW = 32;
   localparam int TW = 4;
   localparam int IB = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [TW-1:0] in_tag = '0;
   logic [3:0]    in_op = '0;
   logic [DW-1:0] in_pc = '0, in_opa = '0, in_opb = '0, in_imm = '0;
   logic [DW-1:0] in_core_res = '0, in_core_npc = '0;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [TW-1:0] out_tag;
   logic          out_pass, out_res_err, out_ctl_err;
   logic [DW-1:0] out_result, out_next_pc;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   rexec_checker #(.DATA_W(DW), .TAG_W(TW), .INSN_BYTES(IB)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_tag(in_tag), .in_op(in_op), .in_pc(in_pc), .in_opa(in_opa),
      .in_opb(in_opb), .in_imm(in_imm), .in_core_res(in_core_res),
      .in_core_npc(in_core_npc), .out_valid(out_valid), .out_ready(out_ready),
      .out_tag(out_tag), .out_pass(out_pass), .out_res_err(out_res_err),
      .out_ctl_err(out_ctl_err), .out_result(out_result), .out_next_pc(out_next_pc)
   );

   task automatic chk(input string req, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] m_res(input logic [3:0] op, input logic [DW-1:0] pc,
      input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] imm);
      case (op)
         4'd0:  return a + b;
         4'd1:  return a - b;
         4'd2:  return a & b;
         4'd3:  return a | b;
         4'd4:  return a ^ b;
         4'd5:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
         4'd6:  return a << b[4:0];
         4'd7:  return a >> b[4:0];
         4'd8:  return a + imm;
         4'd12: return pc + IB;
         default: return '0;
      endcase
   endfunction

   function automatic logic [DW-1:0] m_npc(input logic [3:0] op, input logic [DW-1:0] pc,
      input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] imm);
      logic tk;
      case (op)
         4'd9:  tk = (a == b);
         4'd10: tk = (a != b);
         4'd11: tk = ($signed(a) < $signed(b));
         4'd12: tk = 1'b1;
         default: tk = 1'b0;
      endcase
      return tk ? pc + imm : pc + IB;
   endfunction

   task automatic drive(input logic [TW-1:0] tag, input logic [3:0] op, input logic [DW-1:0] pc,
      input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] imm,
      input logic [DW-1:0] cres, input logic [DW-1:0] cnpc);
      in_valid = 1'b1; in_tag = tag; in_op = op; in_pc = pc; in_opa = a; in_opb = b;
      in_imm = imm; in_core_res = cres; in_core_npc = cnpc;
   endtask

   // One instruction through an idle pipeline, every output compared to the model
   task automatic t_one(input string req, input logic [TW-1:0] tag, input logic [3:0] op,
      input logic [DW-1:0] pc, input logic [DW-1:0] a, input logic [DW-1:0] b,
      input logic [DW-1:0] imm, input logic [DW-1:0] cres, input logic [DW-1:0] cnpc);
      logic [DW-1:0] rr, rn, eres;
      logic cmp, eres_err, ectl;
      rr = m_res(op, pc, a, b, imm);
      rn = m_npc(op, pc, a, b, imm);
      cmp = !(op == 4'd9 || op == 4'd10 || op == 4'd11);
      eres_err = cmp && (cres != rr);
      ectl = (cnpc != rn);
      eres = cmp ? rr : cres;
      out_ready = 1'b1;
      drive(tag, op, pc, a, b, imm, cres, cnpc);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R2", "out_valid", out_valid, 1);
      chk("R2", "out_tag", out_tag, tag);
      chk(req, "out_result", out_result, eres);
      chk(req, "out_next_pc", out_next_pc, rn);
      chk(req, "out_res_err", out_res_err, eres_err);
      chk(req, "out_ctl_err", out_ctl_err, ectl);
      chk(req, "out_pass", out_pass, !(eres_err || ectl));
      @(posedge clk);
      @(negedge clk);
      chk("R2", "drained", out_valid, 0);
   endtask

   task automatic t_reset();
      chk("R1", "out_valid after reset", out_valid, 0);
      chk("R1", "in_ready after reset", in_ready, 1);
   endtask

   task automatic t_alu();
      t_one("R3", 1, 4'd0, 32'h100, 32'hFFFF_FFFF, 32'd2, 0, 32'd1, 32'h104);
      t_one("R3", 2, 4'd1, 32'h100, 32'd3, 32'd5, 0, 32'hFFFF_FFFE, 32'h104);
      t_one("R3", 3, 4'd2, 32'h100, 32'hF0F0, 32'hFF00, 0, 32'hF000, 32'h104);
      t_one("R3", 4, 4'd3, 32'h100, 32'hF0F0, 32'h0F0F, 0, 32'hFFFF, 32'h104);
      t_one("R3", 5, 4'd4, 32'h100, 32'hAAAA, 32'hFFFF, 0, 32'h5555, 32'h104);
      t_one("R3", 6, 4'd5, 32'h100, 32'hFFFF_FFFF, 32'd1, 0, 32'd1, 32'h104);
      t_one("R3", 7, 4'd5, 32'h100, 32'd1, 32'hFFFF_FFFF, 0, 32'd0, 32'h104);
      t_one("R3", 8, 4'd6, 32'h100, 32'h1, 32'h25, 0, 32'h20, 32'h104);
      t_one("R3", 9, 4'd7, 32'h100, 32'h8000_0000, 32'd31, 0, 32'h1, 32'h104);
   endtask

   task automatic t_agen();
      t_one("R4", 1, 4'd8, 32'h200, 32'h1000, 32'h0, 32'hFFFF_FFFC, 32'h0FFC, 32'h204);
      t_one("R4", 2, 4'd8, 32'h200, 32'hFFFF_FFF0, 32'h0, 32'h20, 32'h10, 32'h204);
   endtask

   task automatic t_mismatch();
      t_one("R5", 3, 4'd0, 32'h300, 32'd7, 32'd8, 0, 32'd99, 32'h304);
      t_one("R5", 4, 4'd8, 32'h300, 32'h40, 32'h0, 32'h8, 32'h0, 32'h304);
   endtask

   task automatic t_npc();
      t_one("R6", 5, 4'd2, 32'h400, 32'd1, 32'd1, 0, 32'd1, 32'h408);
      t_one("R6", 6, 4'd0, 32'hFFFF_FFFC, 32'd1, 32'd1, 0, 32'd2, 32'h0);
   endtask

   task automatic t_branch();
      t_one("R7", 7, 4'd9, 32'h500, 32'd5, 32'd5, 32'h40, 32'd0, 32'h540);
      t_one("R7", 8, 4'd9, 32'h500, 32'd5, 32'd6, 32'h40, 32'd0, 32'h540);
      t_one("R7", 9, 4'd10, 32'h500, 32'd5, 32'd6, 32'hFFFF_FFF0, 32'd0, 32'h4F0);
      t_one("R7", 10, 4'd10, 32'h500, 32'd5, 32'd5, 32'h40, 32'd0, 32'h504);
      t_one("R7", 11, 4'd11, 32'h500, 32'h8000_0000, 32'd1, 32'h40, 32'd0, 32'h540);
      t_one("R7", 12, 4'd11, 32'h500, 32'd1, 32'h8000_0000, 32'h40, 32'd0, 32'h504);
   endtask

   task automatic t_branch_res();
      t_one("R8", 13, 4'd9, 32'h600, 32'd1, 32'd1, 32'h10, 32'hDEAD_BEEF, 32'h610);
      t_one("R8", 14, 4'd11, 32'h600, 32'd2, 32'd1, 32'h10, 32'h1234, 32'h604);
   endtask

   task automatic t_jump();
      t_one("R9", 15, 4'd12, 32'h700, 32'd0, 32'd0, 32'h100, 32'h704, 32'h800);
      t_one("R9", 0, 4'd12, 32'h700, 32'd0, 32'd0, 32'h100, 32'h700, 32'h704);
   endtask

   task automatic t_unused();
      t_one("R12", 1, 4'd14, 32'h800, 32'd9, 32'd9, 32'h50, 32'd0, 32'h804);
      t_one("R12", 2, 4'd15, 32'h800, 32'd9, 32'd9, 32'h50, 32'd5, 32'h850);
   endtask

   // Back-to-back stream, outputs every cycle in acceptance order
   task automatic t_stream();
      out_ready = 1'b1;
      for (int j = 0; j < 8; j++) begin
         if (j >= 2) begin
            chk("R10", "stream out_valid", out_valid, 1);
            chk("R10", "stream order", out_tag, 4'(j - 2));
            chk("R10", "stream result", out_result, 32'(j - 2) + 32'd10);
         end
         if (j < 6) begin
            chk("R10", "in_ready in stream", in_ready, 1);
            drive(4'(j), 4'd0, 32'h900, 32'(j), 32'd10, 0, 32'(j) + 32'd10, 32'h904);
         end else begin
            in_valid = 1'b0;
         end
         @(posedge clk);
         @(negedge clk);
      end
      chk("R10", "stream drained", out_valid, 0);
   endtask

   // Stall the output, fill both stages, then release
   task automatic t_backpressure();
      out_ready = 1'b0;
      drive(4'd3, 4'd0, 32'hA00, 32'd1, 32'd1, 0, 32'd2, 32'hA04);
      @(posedge clk); @(negedge clk);
      drive(4'd4, 4'd0, 32'hA04, 32'd2, 32'd2, 0, 32'd4, 32'hA08);
      @(posedge clk); @(negedge clk);
      drive(4'd5, 4'd0, 32'hA08, 32'd3, 32'd3, 0, 32'd6, 32'hA0C);
      chk("R11", "in_ready when full", in_ready, 0);
      for (int k = 0; k < 3; k++) begin
         @(posedge clk); @(negedge clk);
         chk("R11", "held out_valid", out_valid, 1);
         chk("R11", "held out_tag", out_tag, 3);
         chk("R11", "held out_result", out_result, 2);
         chk("R11", "still full", in_ready, 0);
      end
      out_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0;
      chk("R11", "second out_tag", out_tag, 4);
      chk("R11", "second result", out_result, 4);
      @(posedge clk); @(negedge clk);
      chk("R11", "third out_tag", out_tag, 5);
      chk("R11", "third result", out_result, 6);
      @(posedge clk); @(negedge clk);
      chk("R11", "empty after release", out_valid, 0);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_alu();
      t_agen();
      t_mismatch();
      t_npc();
      t_branch();
      t_branch_res();
      t_jump();
      t_unused();
      t_stream();
      t_backpressure();
      finish_run();
   end

endmodule